// File: doc/BRIEF.md
# Command Packet Descriptor Parser

This block takes one command packet held in memory, checks it and breaks it into the pieces a transfer engine needs. A run command with the value 0x107 on the command input starts it. The block then reads the first 52 bytes of a fixed 64-byte packet from a 64-bit base address, one 32-bit word at a time. It checks the two section headers and the valid flag. It then decodes the transfer direction, interrupt enable, DMA/PIO select, 48-bit addressing flag, total byte count and the 20-byte command frame.

After a good header, the block reads the scatter-gather table. The packet itself holds the table's address. The block sends one address/length pair per entry on a valid/ready stream. It adds up the entry lengths and, after the last entry, emits one status record that carries the channel's port number. A bad header ends the packet at once with a header-error status and no stream traffic. The memory port allows one read in flight, and each read is answered by a single `rd_valid` beat.

Top module: `cpd_parser`

## Requirements
- R1: Only a command write whose code equals 0x107 starts a packet. Any other code leaves the block idle, with no memory read issued and `busy` low.
- R2: A packet fetch reads exactly 13 words, at `pkt_base + 4*k` for k = 0..12, in rising order. Each entry reads 3 more words. `rd_en` is a one-cycle pulse, and the next read is issued only after the previous one has returned.
- R3: The header is accepted only when all three of these hold: byte 0 (word 0 bits 7:0) is 0x01, the valid flag (word 0 bit 13) is set, and byte 24 (word 6 bits 7:0) is 0x02. Otherwise the block reports status 1, sends no entries and leaves `params_valid` low.
- R4: After an accepted header, `params_valid` is high and the decoded fields are as follows. `dir_out` is word 0 bit 8. `irq_en` is word 0 bit 12. `byte_count` is word 1. `dma_mode` is word 7 bit 2. `ext48` is word 7 bit 3. `cmd_frame` is words 8..12, with byte 32 in bits 7:0.
- R5: For each entry i below the entry count (word 2), the table address is the 64-bit value in words 5:4. The block sends `ent_addr` = {word at table+16i+4, word at table+16i} and `ent_len` = the word at table+16i+8, in index order.
- R6: While `ent_valid` is high and `ent_ready` is low, `ent_valid`, `ent_addr` and `ent_len` hold their values.
- R7: After the last entry (or at once when the count is zero), the status is 0 if the sum of the entry lengths equals `byte_count`, and 2 if it does not.
- R8: Each started packet produces exactly one single-cycle `sts_valid` pulse, with `sts_port` equal to the PORT_ID parameter. `sts_valid` and `ent_valid` are never high together.
- R9: A run command that arrives while `busy` is high is ignored.
- R10: After reset, `busy`, `rd_en`, `ent_valid`, `sts_valid` and `params_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 16 | Command code; 0x107 runs a packet |
| pkt_base | input | 64 | Packet base address, sampled at start |
| rd_en | output | 1 | Memory read request pulse |
| rd_addr | output | 64 | Byte address of the requested word |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | 32 | Returned word |
| busy | output | 1 | A packet is in progress |
| params_valid | output | 1 | Decoded fields are valid |
| dir_out | output | 1 | Transfer direction is out |
| irq_en | output | 1 | Interrupt enable flag |
| dma_mode | output | 1 | DMA (1) versus PIO (0) |
| ext48 | output | 1 | 48-bit addressing |
| byte_count | output | 32 | Total transfer bytes |
| cmd_frame | output | 160 | Command frame, byte 32 in bits 7:0 |
| ent_valid | output | 1 | Table entry available |
| ent_ready | input | 1 | Consumer accepts entry |
| ent_addr | output | 64 | Entry buffer address |
| ent_len | output | 32 | Entry length in bytes |
| sts_valid | output | 1 | Status record pulse |
| sts_code | output | 6 | 0 ok, 1 header error, 2 length mismatch |
| sts_port | output | PORT_W | Port number of this channel |

## Verification
The bench builds the block with PORT_ID = 2 and PORT_W = 2, so a status record that drops or swaps the port number shows up as a wrong value rather than a zero. The memory model answers one cycle after each request. Entry backpressure is either absent or applied on alternate cycles, so the block must hold an entry through stalled handshakes. It must also count its fetch beats exactly. The table is placed apart from the packet, and entries carry nonzero upper address words, so both halves of every 64-bit field are checked.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PREQ, S_PWAIT, S_CHECK, S_EREQ, S_EWAIT, S_EOUT, S_STAT
  } cpd_state_e;

  localparam logic [15:0] CMD_RUN  = 16'h0107;
  localparam logic [7:0]  HOST_HDR = 8'h01;
  localparam logic [7:0]  DEV_HDR  = 8'h02;
  localparam logic [5:0]  ST_OK    = 6'd0;
  localparam logic [5:0]  ST_HDR   = 6'd1;
  localparam logic [5:0]  ST_LEN   = 6'd2;
endpackage

// File: rtl/cpd_hdr_check.sv
module cpd_hdr_check
  import cpd_pkg::*;
(
  input  logic [7:0] host_hdr,
  input  logic [7:0] dev_hdr,
  input  logic       valid_flag,
  output logic       hdr_ok
);
  always_comb begin
    hdr_ok = (host_hdr == HOST_HDR) && valid_flag && (dev_hdr == DEV_HDR);
  end
endmodule

// File: rtl/cpd_len_acc.sv
module cpd_len_acc #(
  parameter int LEN_W = 32,
  parameter int SUM_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [LEN_W-1:0] add_len,
  input  logic [LEN_W-1:0] total,
  output logic             match
);
  logic [SUM_W-1:0] sum_q, sum_d;

  always_comb begin
    sum_d = sum_q;
    if (clr)         sum_d = '0;
    else if (add_en) sum_d = sum_q + SUM_W'(add_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sum_q <= '0;
    else if (clr || add_en)   sum_q <= sum_d;
  end

  assign match = (sum_q == SUM_W'(total));
endmodule

// File: rtl/cpd_parser.sv
module cpd_parser
  import cpd_pkg::*;
#(
  parameter int PORT_W  = 2,
  parameter int PORT_ID = 0,
  parameter int AW      = 64,
  parameter int WW      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [15:0]       cmd_code,
  input  logic [AW-1:0]     pkt_base,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_valid,
  input  logic [WW-1:0]     rd_data,
  output logic              busy,
  output logic              params_valid,
  output logic              dir_out,
  output logic              irq_en,
  output logic              dma_mode,
  output logic              ext48,
  output logic [WW-1:0]     byte_count,
  output logic [5*WW-1:0]   cmd_frame,
  output logic              ent_valid,
  input  logic              ent_ready,
  output logic [AW-1:0]     ent_addr,
  output logic [WW-1:0]     ent_len,
  output logic              sts_valid,
  output logic [5:0]        sts_code,
  output logic [PORT_W-1:0] sts_port
);
  localparam int PKT_WORDS   = 13;
  localparam int FRAME_FIRST = 8;
  localparam int FRAME_WORDS = PKT_WORDS - FRAME_FIRST;
  localparam int WI_W        = $clog2(PKT_WORDS);
  localparam logic [PORT_W-1:0] PORT_VAL = PORT_W'(PORT_ID);

  cpd_state_e          state_q, state_d;
  logic [WI_W-1:0]     widx_q;
  logic [1:0]          sub_q;
  logic [WW-1:0]       eidx_q;
  logic [AW-1:0]       base_q;
  logic [WW-1:0]       pkt_q [PKT_WORDS];
  logic [WW-1:0]       e_lo_q, e_hi_q, e_len_q;
  logic                pv_q;
  logic [5:0]          code_q, code_d;
  logic                load_base, pkt_we, ent_we, hs, hdr_ok, len_match;
  logic [AW-1:0]       tbl_addr;

  cpd_hdr_check u_hdr (
    .host_hdr   (pkt_q[0][7:0]),
    .dev_hdr    (pkt_q[6][7:0]),
    .valid_flag (pkt_q[0][13]),
    .hdr_ok     (hdr_ok)
  );

  cpd_len_acc #(.LEN_W(WW), .SUM_W(2*WW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load_base),
    .add_en  (hs),
    .add_len (e_len_q),
    .total   (pkt_q[1]),
    .match   (len_match)
  );

  assign tbl_addr = {pkt_q[5], pkt_q[4]};

  always_comb begin
    state_d   = state_q;
    rd_en     = 1'b0;
    rd_addr   = '0;
    load_base = 1'b0;
    pkt_we    = 1'b0;
    ent_we    = 1'b0;
    hs        = 1'b0;
    code_d    = code_q;
    case (state_q)
      S_IDLE: if (cmd_we && cmd_code == CMD_RUN) begin
        load_base = 1'b1;
        state_d   = S_PREQ;
      end
      S_PREQ: begin
        rd_en   = 1'b1;
        rd_addr = base_q + AW'({widx_q, 2'b00});
        state_d = S_PWAIT;
      end
      S_PWAIT: if (rd_valid) begin
        pkt_we  = 1'b1;
        state_d = (widx_q == WI_W'(PKT_WORDS - 1)) ? S_CHECK : S_PREQ;
      end
      S_CHECK: begin
        if (!hdr_ok) begin
          code_d  = ST_HDR;
          state_d = S_STAT;
        end else if (eidx_q == pkt_q[2]) begin
          code_d  = len_match ? ST_OK : ST_LEN;
          state_d = S_STAT;
        end else begin
          state_d = S_EREQ;
        end
      end
      S_EREQ: begin
        rd_en   = 1'b1;
        rd_addr = tbl_addr + AW'({eidx_q, 4'b0000}) + AW'({sub_q, 2'b00});
        state_d = S_EWAIT;
      end
      S_EWAIT: if (rd_valid) begin
        ent_we  = 1'b1;
        state_d = (sub_q == 2'd2) ? S_EOUT : S_EREQ;
      end
      S_EOUT: if (ent_ready) begin
        hs      = 1'b1;
        state_d = S_CHECK;
      end
      S_STAT:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      widx_q  <= '0;
      sub_q   <= '0;
      eidx_q  <= '0;
      base_q  <= '0;
      pv_q    <= 1'b0;
      code_q  <= ST_OK;
      e_lo_q  <= '0;
      e_hi_q  <= '0;
      e_len_q <= '0;
      for (int i = 0; i < PKT_WORDS; i++) pkt_q[i] <= '0;
    end else begin
      state_q <= state_d;
      code_q  <= code_d;
      if (load_base) begin
        base_q <= pkt_base;
        widx_q <= '0;
        sub_q  <= '0;
        eidx_q <= '0;
        pv_q   <= 1'b0;
      end
      if (pkt_we) begin
        pkt_q[widx_q] <= rd_data;
        widx_q        <= widx_q + 1'b1;
      end
      if (state_q == S_CHECK && hdr_ok) pv_q <= 1'b1;
      if (ent_we) begin
        case (sub_q)
          2'd0:    e_lo_q  <= rd_data;
          2'd1:    e_hi_q  <= rd_data;
          default: e_len_q <= rd_data;
        endcase
        sub_q <= (sub_q == 2'd2) ? 2'd0 : sub_q + 1'b1;
      end
      if (hs) eidx_q <= eidx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < FRAME_WORDS; g++) begin : g_frame
    assign cmd_frame[g*WW +: WW] = pkt_q[FRAME_FIRST + g];
  end

  assign busy         = (state_q != S_IDLE);
  assign params_valid = pv_q;
  assign dir_out      = pkt_q[0][8];
  assign irq_en       = pkt_q[0][12];
  assign dma_mode     = pkt_q[7][2];
  assign ext48        = pkt_q[7][3];
  assign byte_count   = pkt_q[1];
  assign ent_valid    = (state_q == S_EOUT);
  assign ent_addr     = {e_hi_q, e_lo_q};
  assign ent_len      = e_len_q;
  assign sts_valid    = (state_q == S_STAT);
  assign sts_code     = code_q;
  assign sts_port     = PORT_VAL;
endmodule

// File: rtl/cpd_parser_chk.sv
module cpd_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_en,
  input logic        params_valid,
  input logic        ent_valid,
  input logic        ent_ready,
  input logic [63:0] ent_addr,
  input logic [31:0] ent_len,
  input logic        sts_valid,
  input logic [5:0]  sts_code
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_en && !ent_valid && !sts_valid)); // R1
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R2
  AST_ENT_NEEDS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> params_valid); // R3
  AST_ENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_addr) && $stable(ent_len))); // R6
  AST_STS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> (sts_code <= 6'd2)); // R7
  AST_STS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |=> !sts_valid); // R8
  AST_STS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sts_valid && ent_valid)); // R8
endmodule

bind cpd_parser cpd_parser_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .rd_en        (rd_en),
  .params_valid (params_valid),
  .ent_valid    (ent_valid),
  .ent_ready    (ent_ready),
  .ent_addr     (ent_addr),
  .ent_len      (ent_len),
  .sts_valid    (sts_valid),
  .sts_code     (sts_code)
);

// File: tb/test_cpd_parser.sv
`timescale 1ns/1ps
module test_cpd_parser;
  localparam int PW = 2;
  localparam int PID = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 1'b0, ent_ready = 1'b0;
  logic [15:0] cmd_code = '0;
  logic [63:0] pkt_base = 64'h100;
  logic rd_en, rd_valid = 1'b0;
  logic [63:0] rd_addr;
  logic [31:0] rd_data = '0;
  logic busy, params_valid, dir_out, irq_en, dma_mode, ext48;
  logic [31:0] byte_count, ent_len;
  logic [159:0] cmd_frame;
  logic ent_valid, sts_valid;
  logic [63:0] ent_addr;
  logic [5:0] sts_code;
  logic [PW-1:0] sts_port;

  logic [31:0] mem [0:255];
  logic [63:0] exp_addr [0:7];
  logic [31:0] exp_len [0:7];
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    rd_valid <= rd_en;
    rd_data  <= mem[rd_addr[9:2]];
  end

  cpd_parser #(.PORT_W(PW), .PORT_ID(PID)) i_cpd_parser (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .pkt_base(pkt_base), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .params_valid(params_valid), .dir_out(dir_out), .irq_en(irq_en),
    .dma_mode(dma_mode), .ext48(ext48), .byte_count(byte_count),
    .cmd_frame(cmd_frame), .ent_valid(ent_valid), .ent_ready(ent_ready),
    .ent_addr(ent_addr), .ent_len(ent_len), .sts_valid(sts_valid),
    .sts_code(sts_code), .sts_port(sts_port)
  );

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_pkt(input logic [7:0] h0, input logic [7:0] fl, input logic [31:0] cnt,
                         input logic [31:0] n, input logic [7:0] h24, input logic [7:0] df);
    mem[64] = {16'h0, fl, h0};
    mem[65] = cnt;
    mem[66] = n;
    mem[67] = 32'h0;
    mem[68] = 32'h200;
    mem[69] = 32'h0;
    mem[70] = {24'h0, h24};
    mem[71] = {24'h0, df};
    for (int i = 0; i < 5; i++) mem[72+i] = 32'hA0B0C000 + 32'(i * 32'h01010101) + cnt;
  endtask

  task automatic put_ent(input int i, input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] len);
    mem[128+4*i]   = lo;
    mem[128+4*i+1] = hi;
    mem[128+4*i+2] = len;
    mem[128+4*i+3] = 32'hDEAD0000;
    exp_addr[i] = {hi, lo};
    exp_len[i]  = len;
  endtask

  task automatic run_pkt(input bit stall, input bit poke, input int n_exp,
                         input logic [5:0] exp_code, input string req_code);
    int got = 0, nrd = 0, nsts = 0, extra = 0;
    logic [5:0] code_seen = '1;
    logic [PW-1:0] port_seen = '0;
    logic [63:0] first_addr = '1;
    @(negedge clk);
    cmd_we = 1'b1; cmd_code = 16'h0107;
    @(negedge clk);
    cmd_we = 1'b0;
    for (int cyc = 0; cyc < 3000 && nsts == 0; cyc++) begin
      ent_ready = stall ? cyc[0] : 1'b1;
      cmd_we = poke && (cyc == 6);
      if (rd_en) begin
        if (nrd == 0) first_addr = rd_addr;
        nrd++;
      end
      if (ent_valid && ent_ready) begin
        if (got < 8) begin
          chk("R5 entry addr", 160'(ent_addr), 160'(exp_addr[got]));
          chk("R5 entry len", 160'(ent_len), 160'(exp_len[got]));
        end
        got++;
      end
      if (sts_valid) begin
        nsts++; code_seen = sts_code; port_seen = sts_port;
      end
      @(negedge clk);
    end
    cmd_we = 1'b0; ent_ready = 1'b0;
    if (nsts == 0) chk("watchdog R8 status seen", 0, 1);
    for (int k = 0; k < 15; k++) begin
      if (sts_valid || busy) extra++;
      @(negedge clk);
    end
    chk("R5 entry count", 160'(got), 160'(n_exp));
    chk("R2 first read addr", 160'(first_addr), 160'(pkt_base));
    chk("R2 read count", 160'(nrd), 160'(13 + 3 * n_exp));
    chk(req_code, 160'(code_seen), 160'(exp_code));
    chk("R8 port", 160'(port_seen), 160'(PID));
    chk(poke ? "R9 single status while busy" : "R8 single status", 160'(extra), 0);
  endtask

  task automatic t_reset;
    chk("R10 busy", 160'(busy), 0);
    chk("R10 rd_en", 160'(rd_en), 0);
    chk("R10 ent_valid", 160'(ent_valid), 0);
    chk("R10 sts_valid", 160'(sts_valid), 0);
    chk("R10 params_valid", 160'(params_valid), 0);
  endtask

  task automatic t_ignored_code;
    int seen = 0;
    @(negedge clk);
    cmd_we = 1'b1; cmd_code = 16'h0106;
    @(negedge clk);
    cmd_we = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (rd_en || busy) seen++;
      @(negedge clk);
    end
    chk("R1 wrong code ignored", 160'(seen), 0);
  endtask

  task automatic t_good;
    put_pkt(8'h01, 8'h39, 32'h600, 3, 8'h02, 8'h0C);
    put_ent(0, 32'h1000, 32'h00000001, 32'h100);
    put_ent(1, 32'h2000, 32'h00000002, 32'h200);
    put_ent(2, 32'h3000, 32'hFFFF0000, 32'h300);
    run_pkt(1'b0, 1'b0, 3, 6'd0, "R7 matching sum status");
    chk("R4 params_valid", 160'(params_valid), 1);
    chk("R4 dir_out", 160'(dir_out), 1);
    chk("R4 irq_en", 160'(irq_en), 1);
    chk("R4 dma_mode", 160'(dma_mode), 1);
    chk("R4 ext48", 160'(ext48), 1);
    chk("R4 byte_count", 160'(byte_count), 160'h600);
    chk("R4 frame", cmd_frame, {mem[76], mem[75], mem[74], mem[73], mem[72]});
  endtask

  task automatic t_stall_mismatch;
    put_pkt(8'h01, 8'h28, 32'h40, 2, 8'h02, 8'h04);
    put_ent(0, 32'hAAAA0000, 32'h12345678, 32'h10);
    put_ent(1, 32'hBBBB0000, 32'h0, 32'h20);
    run_pkt(1'b1, 1'b0, 2, 6'd2, "R7 mismatch status R6 stall");
    chk("R4 dir_out clear", 160'(dir_out), 0);
    chk("R4 irq_en clear", 160'(irq_en), 0);
    chk("R4 ext48 clear", 160'(ext48), 0);
  endtask

  task automatic t_zero;
    put_pkt(8'h01, 8'h20, 32'h0, 0, 8'h02, 8'h00);
    run_pkt(1'b0, 1'b0, 0, 6'd0, "R7 zero entries status");
  endtask

  task automatic t_bad(input logic [7:0] h0, input logic [7:0] fl, input logic [7:0] h24, input string req);
    put_pkt(h0, fl, 32'h10, 1, h24, 8'h04);
    put_ent(0, 32'h5000, 32'h0, 32'h10);
    run_pkt(1'b0, 1'b0, 0, 6'd1, req);
    chk("R3 params_valid low", 160'(params_valid), 0);
  endtask

  task automatic t_poke;
    put_pkt(8'h01, 8'h20, 32'h80, 1, 8'h02, 8'h04);
    put_ent(0, 32'h7000, 32'h0, 32'h80);
    run_pkt(1'b0, 1'b1, 1, 6'd0, "R9 status after busy command");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ignored_code();
    t_good();
    t_stall_mismatch();
    t_zero();
    t_bad(8'h03, 8'h20, 8'h02, "R3 bad host header");
    t_bad(8'h01, 8'h18, 8'h02, "R3 valid flag clear");
    t_bad(8'h01, 8'h20, 8'h05, "R3 bad device header");
    t_poke();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule